// File: doc/BRIEF.md
# Add/Subtract/Negate Unit with Status Flags

This block is an integer arithmetic unit of parameterised width. It computes a sum, a sum with the stored carry folded in, a difference or a two's-complement negation. All four share one ripple-carry adder. The second operand is inverted and the adder's carry-in is forced high to turn the adder into a subtractor. The result is combinational and is valid in the same cycle the operands and operation code are presented.

Four status flags are derived from each result: negative, zero, carry and signed overflow. They are captured into a status register on the rising clock edge when the flag-update enable is high. Signed overflow comes from comparing the carry entering the top bit with the carry leaving it, so the one input whose negation cannot be represented is flagged with no special-case logic. The stored carry feeds back into the add-with-carry operation, which lets wider sums be chained across several cycles.

Top module: `arith_flag_unit`

## Requirements
- R1: With `op_sel` = 2'b00 (add), `result` equals `opa + opb` modulo 2^WIDTH, and the captured carry flag is the carry out of the top bit.
- R2: With `op_sel` = 2'b01 (add with carry), `result` equals `opa + opb + C` modulo 2^WIDTH, where C is the carry flag held in the status register before the clock edge.
- R3: With `op_sel` = 2'b10 (subtract), `result` equals `opa - opb` modulo 2^WIDTH, and the captured carry flag is 1 exactly when `opa >= opb` as unsigned values (1 means no borrow).
- R4: With `op_sel` = 2'b11 (negate), `result` equals `0 - opb` modulo 2^WIDTH, and `opa` has no effect on the result or on the flags.
- R5: The captured overflow flag is 1 exactly when the signed result of the selected operation lies outside the range of a WIDTH-bit two's-complement value.
- R6: Negating the most negative value (8'h80 at the default width) returns the same bit pattern with overflow 1 and carry 0. Negating zero returns zero with carry 1 and overflow 0.
- R7: The captured negative flag equals the top bit of `result`, and the captured zero flag is 1 exactly when `result` is all zeros.
- R8: A high `rst` at a rising edge clears all four flags. When `flag_we` is low at a rising edge, the flags keep their previous values. When `flag_we` is high, they take the values of the current result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; the flag register updates on the rising edge |
| rst | input | 1 | Synchronous active-high reset of the flag register |
| op_sel | input | 2 | Operation code: 00 add, 01 add with carry, 10 subtract, 11 negate |
| opa | input | WIDTH | First operand (ignored by negate) |
| opb | input | WIDTH | Second operand |
| flag_we | input | 1 | Flag-update enable |
| result | output | WIDTH | Combinational result of the selected operation |
| flag_n | output | 1 | Stored negative flag |
| flag_z | output | 1 | Stored zero flag |
| flag_c | output | 1 | Stored carry flag (no-borrow for subtract and negate) |
| flag_v | output | 1 | Stored signed-overflow flag |

## Verification
The clocked assertions assume that `op_sel`, both operands and `flag_we` are steady for the whole cycle before each rising edge. They also assume those inputs carry known values whenever reset is low, because the flag checks compare the register against the inputs one edge earlier.

The stimulus meets these assumptions by changing every input only on the falling clock edge, and by driving defined values from the first cycle. Add-with-carry cases are preceded by operations that set the carry flag to a known state, so the stored carry the assertions rely on is always defined.

// File: rtl/afu_pkg.sv
package afu_pkg;

  typedef enum logic [1:0] {
    OP_ADD = 2'b00,
    OP_ADC = 2'b01,
    OP_SUB = 2'b10,
    OP_NEG = 2'b11
  } afu_op_e;

  typedef struct packed {
    logic neg;
    logic zero;
    logic carry;
    logic ovf;
  } afu_flags_t;

endpackage

// File: rtl/afu_operand_mux.sv
module afu_operand_mux
  import afu_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  afu_op_e          op,
  input  logic [WIDTH-1:0] a_in,
  input  logic [WIDTH-1:0] b_in,
  input  logic             stored_carry,
  output logic [WIDTH-1:0] a_eff,
  output logic [WIDTH-1:0] b_eff,
  output logic             cin
);

  // Negate runs as zero minus B; subtract as A plus inverted B plus one.
  always_comb begin
    a_eff = a_in;
    b_eff = b_in;
    cin   = 1'b0;
    unique case (op)
      OP_ADD: cin = 1'b0;
      OP_ADC: cin = stored_carry;
      OP_SUB: begin
        b_eff = ~b_in;
        cin   = 1'b1;
      end
      OP_NEG: begin
        a_eff = '0;
        b_eff = ~b_in;
        cin   = 1'b1;
      end
      default: cin = 1'b0;
    endcase
  end

endmodule

// File: rtl/afu_ripple_adder.sv
module afu_ripple_adder #(
  parameter int WIDTH = 8
) (
  input  logic [WIDTH-1:0] a,
  input  logic [WIDTH-1:0] b,
  input  logic             cin,
  output logic [WIDTH-1:0] sum,
  output logic             carry_msb_in,
  output logic             carry_out
);

  localparam int MSB = WIDTH - 1;

  logic [WIDTH:0] chain;

  assign chain[0] = cin;

  for (genvar i = 0; i < WIDTH; i++) begin : g_stage
    assign sum[i]       = a[i] ^ b[i] ^ chain[i];
    assign chain[i + 1] = (a[i] & b[i]) | (chain[i] & (a[i] ^ b[i]));
  end

  assign carry_msb_in = chain[MSB];
  assign carry_out    = chain[WIDTH];

  always_comb begin
    AST_RIPPLE_SUM: assert ({carry_out, sum} ==
                            ({1'b0, a} + {1'b0, b} + {{WIDTH{1'b0}}, cin})); // R1
  end

endmodule

// File: rtl/afu_flag_gen.sv
module afu_flag_gen
  import afu_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic [WIDTH-1:0] sum,
  input  logic             carry_msb_in,
  input  logic             carry_out,
  output afu_flags_t       flags
);

  localparam int MSB = WIDTH - 1;

  always_comb begin
    flags.neg   = sum[MSB];
    flags.zero  = (sum == '0);
    flags.carry = carry_out;
    flags.ovf   = carry_msb_in ^ carry_out;
  end

endmodule

// File: rtl/arith_flag_unit.sv
module arith_flag_unit
  import afu_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [1:0]       op_sel,
  input  logic [WIDTH-1:0] opa,
  input  logic [WIDTH-1:0] opb,
  input  logic             flag_we,
  output logic [WIDTH-1:0] result,
  output logic             flag_n,
  output logic             flag_z,
  output logic             flag_c,
  output logic             flag_v
);

  localparam int              MSB     = WIDTH - 1;
  localparam logic [WIDTH-1:0] MIN_NEG = {1'b1, {(WIDTH-1){1'b0}}};

  afu_op_e          op;
  logic [WIDTH-1:0] a_eff;
  logic [WIDTH-1:0] b_eff;
  logic             cin;
  logic             c_msb_in;
  logic             c_out;
  afu_flags_t       next_flags;
  afu_flags_t       flag_q;

  assign op = afu_op_e'(op_sel);

  afu_operand_mux #(.WIDTH(WIDTH)) u_mux (
    .op           (op),
    .a_in         (opa),
    .b_in         (opb),
    .stored_carry (flag_q.carry),
    .a_eff        (a_eff),
    .b_eff        (b_eff),
    .cin          (cin)
  );

  afu_ripple_adder #(.WIDTH(WIDTH)) u_adder (
    .a            (a_eff),
    .b            (b_eff),
    .cin          (cin),
    .sum          (result),
    .carry_msb_in (c_msb_in),
    .carry_out    (c_out)
  );

  afu_flag_gen #(.WIDTH(WIDTH)) u_flags (
    .sum          (result),
    .carry_msb_in (c_msb_in),
    .carry_out    (c_out),
    .flags        (next_flags)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      flag_q <= '0;
    end else if (flag_we) begin
      flag_q <= next_flags;
    end
  end

  assign flag_n = flag_q.neg;
  assign flag_z = flag_q.zero;
  assign flag_c = flag_q.carry;
  assign flag_v = flag_q.ovf;

  AST_RESET_CLEAR: assert property (@(posedge clk)
    rst |=> ({flag_n, flag_z, flag_c, flag_v} == 4'b0000)); // R8

  AST_FLAGS_HOLD: assert property (@(posedge clk) disable iff (rst)
    !flag_we |=> $stable({flag_n, flag_z, flag_c, flag_v})); // R8

  AST_ZERO_NEG: assert property (@(posedge clk) disable iff (rst)
    flag_we |=> (flag_z == ($past(result) == '0)) && (flag_n == $past(result[MSB]))); // R7

  AST_SUB_CARRY: assert property (@(posedge clk) disable iff (rst)
    (flag_we && op_sel == 2'b10) |=> (flag_c == ($past(opa) >= $past(opb)))); // R3

  AST_ADD_OVF: assert property (@(posedge clk) disable iff (rst)
    (flag_we && op_sel == 2'b00) |=>
      (flag_v == (($past(opa[MSB]) == $past(opb[MSB])) &&
                  ($past(result[MSB]) != $past(opa[MSB]))))); // R5

  AST_NEG_VALUE: assert property (@(posedge clk) disable iff (rst)
    (op_sel == 2'b11) |-> (result == ({WIDTH{1'b0}} - opb))); // R4

  AST_NEG_MIN: assert property (@(posedge clk) disable iff (rst)
    (flag_we && op_sel == 2'b11 && opb == MIN_NEG) |=> (flag_v && !flag_c)); // R6

endmodule

// File: tb/arith_flag_unit_bench.sv
module arith_flag_unit_bench;

  localparam int W = 8;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic [1:0]   op_sel = 2'b00;
  logic [W-1:0] opa = '0;
  logic [W-1:0] opb = '0;
  logic         flag_we = 1'b0;
  logic [W-1:0] result;
  logic         flag_n, flag_z, flag_c, flag_v;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  logic [W-1:0] q_res[$];
  logic [3:0]   q_flg[$];
  string        q_req[$];

  logic [3:0] model_flags = 4'b0000; // {n,z,c,v}

  arith_flag_unit #(.WIDTH(W)) u_arith_flag_unit (
    .clk(clk), .rst(rst), .op_sel(op_sel), .opa(opa), .opb(opb),
    .flag_we(flag_we), .result(result),
    .flag_n(flag_n), .flag_z(flag_z), .flag_c(flag_c), .flag_v(flag_v)
  );

  always #5 clk = ~clk;

  task automatic check(input string req, input string what,
                       input logic [W-1:0] act, input logic [W-1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  // Driver: compute the expected outcome from the requirements and queue it.
  task automatic drive(input logic [1:0] op, input logic [W-1:0] a,
                       input logic [W-1:0] b, input logic we, input string req);
    int sa, sb, sr, ua, ub, us;
    logic [W-1:0] r;
    logic c, v;
    sa = int'($signed(a));
    sb = int'($signed(b));
    ua = int'(a);
    ub = int'(b);
    case (op)
      2'b00: begin us = ua + ub; c = (us > 255); sr = sa + sb; end
      2'b01: begin us = ua + ub + int'(model_flags[1]); c = (us > 255);
                   sr = sa + sb + int'(model_flags[1]); end
      2'b10: begin us = ua - ub; c = (ua >= ub); sr = sa - sb; end
      default: begin us = 0 - ub; c = (ub == 0); sr = 0 - sb; end
    endcase
    r = W'(us);
    v = (sr > 127) || (sr < -128);
    if (we) model_flags = {r[W-1], (r == '0), c, v};
    @(negedge clk);
    op_sel  = op;
    opa     = a;
    opb     = b;
    flag_we = we;
    q_res.push_back(r);
    q_flg.push_back(model_flags);
    q_req.push_back(req);
  endtask

  // Monitor: result before the edge, flags after it.
  initial begin
    forever begin
      @(negedge clk);
      #2;
      if (q_res.size() > 0) begin
        logic [W-1:0] er;
        logic [3:0] ef;
        string rq;
        er = q_res.pop_front();
        ef = q_flg.pop_front();
        rq = q_req.pop_front();
        check(rq, "result", result, er);
        @(posedge clk);
        #1;
        check(rq, "flags{n,z,c,v}", {4'b0, flag_n, flag_z, flag_c, flag_v}, {4'b0, ef});
      end
    end
  end

  initial begin
    #(200000 * 10);
    if (!done) begin
      done = 1'b1;
      fails++;
      checks++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    logic [W-1:0] lfsr;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    #1;
    check("R8", "flags after reset", {4'b0, flag_n, flag_z, flag_c, flag_v}, 8'h00);

    drive(2'b00, 8'h00, 8'h01, 1'b1, "R1");
    drive(2'b00, 8'd200, 8'd100, 1'b1, "R1");   // carry out
    drive(2'b01, 8'h10, 8'h20, 1'b1, "R2");     // stored carry 1 -> 0x31
    drive(2'b01, 8'h10, 8'h20, 1'b1, "R2");     // stored carry now 0
    drive(2'b00, 8'h7F, 8'h01, 1'b1, "R5");     // positive overflow
    drive(2'b00, 8'h80, 8'hFF, 1'b1, "R5");     // negative overflow
    drive(2'b10, 8'd5, 8'd3, 1'b1, "R3");
    drive(2'b10, 8'd3, 8'd5, 1'b1, "R3");       // borrow
    drive(2'b10, 8'h80, 8'h01, 1'b1, "R5");     // subtract overflow
    drive(2'b10, 8'h42, 8'h42, 1'b1, "R7");     // zero result
    drive(2'b11, 8'h00, 8'h80, 1'b1, "R6");
    drive(2'b11, 8'hAA, 8'h00, 1'b1, "R6");
    drive(2'b11, 8'hFF, 8'h05, 1'b1, "R4");     // A ignored
    drive(2'b11, 8'h00, 8'h05, 1'b1, "R4");
    drive(2'b00, 8'hF0, 8'h20, 1'b1, "R1");     // set carry
    drive(2'b00, 8'h01, 8'h01, 1'b0, "R8");     // hold
    drive(2'b01, 8'hFF, 8'h00, 1'b1, "R2");     // carry ripples all bits
    lfsr = 8'hA5;
    for (int i = 0; i < 40; i++) begin
      logic [W-1:0] x, y;
      lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
      x = lfsr;
      lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
      y = lfsr;
      drive(2'(i % 4), x, y, (i % 5) != 0, "R5");
    end
    drive(2'b00, 8'h90, 8'h90, 1'b1, "R7");
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    #1;
    check("R8", "flags after second reset", {4'b0, flag_n, flag_z, flag_c, flag_v}, 8'h00);
    if (!done) begin
      done = 1'b1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

endmodule